// File: doc/BRIEF.md
# Step Attenuator Latched-Mode Programming Sequencer

This block sits on the host side of a board-level step attenuator whose six control inputs are captured by a latch-enable strobe. A client asks for an attenuation as an unsigned count of half-decibel steps over a valid/ready handshake. The sequencer turns the count into the six-bit control word, drives it onto the control pins, and then generates the strobe. The data lines are settled before the strobe rises, the strobe is high for at least a minimum time, and the data lines stay untouched for a hold window after it falls. A new update is not started until a minimum spacing has passed since the previous one, which caps the update rate at 1 MHz.

All windows are given as nanosecond parameters together with the system clock frequency in MHz. Each window is converted to whole clock cycles and rounded up, with a floor of one cycle. Bit i of the six-bit word carries 0.5·2^i dB, so the word equals the step count. Requests wider than six bits are clipped to the top step, and a sticky flag records that clipping has happened. Back-pressure follows the usual rule. The client holds `req_valid` and `req_steps` steady until it sees `req_ready` high at a rising clock edge. `req_ready` is high only while the sequencer is idle. One transfer happens on every edge where both are high.

Top module: `atten_latch_seq`

## Requirements
- R1: A request of 63 steps or fewer is placed unchanged on `ctl_word`, with bit i weighted 0.5·2^i dB. The word appears in the cycle after the handshake edge.
- R2: A request above 63 steps places 63 (all six bits set) on `ctl_word`.
- R3: `clip_seen` goes high after a clipped request is accepted. Only reset clears it. A request of exactly 63 does not set it.
- R4: Before `ctl_le` rises, `ctl_word` is stable and `ctl_le` is low for exactly SETUP_CYC cycles. SETUP_CYC = ceil(SETUP_NS·CLK_MHZ/1000), with a minimum of 1.
- R5: Every `ctl_le` high pulse lasts exactly PULSE_CYC cycles, derived from PULSE_NS in the same way.
- R6: After `ctl_le` falls, `ctl_word` stays unchanged for at least HOLD_CYC cycles, derived from HOLD_NS in the same way.
- R7: `ctl_word` changes only in a cycle where `ctl_le` is low and was low in the cycle before.
- R8: Two accepted requests are at least SPACE_CYC cycles apart. SPACE_CYC is the larger of ceil(PERIOD_NS·CLK_MHZ/1000) and SETUP_CYC+PULSE_CYC+HOLD_CYC+1.
- R9: `req_ready` is high only while idle and never while `ctl_le` is high. A request held valid during a busy period is accepted exactly once, and each accepted request produces exactly one strobe.
- R10: During and right after reset, `ctl_le` is 0, `ctl_word` is 0, `req_ready` is 1 and `clip_seen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_steps | input | REQ_W | Requested attenuation in half-decibel steps |
| ctl_word | output | CODE_W | Control word driven to the attenuator |
| ctl_le | output | 1 | Latch-enable strobe to the attenuator |
| clip_seen | output | 1 | Sticky flag: a request was clipped to the top step |

## Verification
The bench uses non-trivial window lengths (25/15/35 ns at 100 MHz, giving 3/2/4 cycles). A design that truncated the conversion instead of rounding up would show setup and pulse windows one cycle too short. Requests of 63, 64 and 255 probe the clip boundary: an off-by-one comparator would either flag 63 or wrap 64 to zero. Back-to-back requests held valid through the busy period check the spacing limit and the rule of one transfer per request. A design that re-accepted a held request, or reopened ready too early, would produce extra strobes or updates closer together than the spacing limit. Every word change is also measured against the last strobe, which catches data moving inside the hold window or while the strobe is high.

// File: rtl/atten_seq_pkg.sv
package atten_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_e;

  // Round a duration in ns up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int dur_ns, input int clk_mhz);
    int c;
    c = (dur_ns * clk_mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/atten_code_sat.sv
module atten_code_sat #(
  parameter int IN_W   = 8,
  parameter int CODE_W = 6
) (
  input  logic [IN_W-1:0]   steps_in,
  output logic [CODE_W-1:0] code_out,
  output logic              clipped
);
  generate
    if (IN_W > CODE_W) begin : g_wide
      logic over;
      assign over     = |steps_in[IN_W-1:CODE_W];
      assign clipped  = over;
      assign code_out = over ? {CODE_W{1'b1}} : steps_in[CODE_W-1:0];
    end else begin : g_narrow
      assign clipped  = 1'b0;
      assign code_out = CODE_W'(steps_in);
    end
  endgenerate
endmodule

// File: rtl/atten_space_timer.sv
module atten_space_timer #(
  parameter int SPACE_CYC = 100,
  parameter int CNT_W     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (start)           remain <= CNT_W'(SPACE_CYC - 1);
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign done = (remain == '0);

  // Assertion support: cycles since the previous start, saturating.
  logic [CNT_W-1:0] since_start;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 since_start <= CNT_W'(SPACE_CYC);
    else if (start)                             since_start <= CNT_W'(1);
    else if (since_start < CNT_W'(SPACE_CYC))   since_start <= since_start + 1'b1;
  end

  AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> since_start >= CNT_W'(SPACE_CYC)); // R8
endmodule

// File: rtl/atten_seq_fsm.sv
module atten_seq_fsm
  import atten_seq_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] code_in,
  input  logic              space_done,
  output logic              req_ready,
  output logic              accept,
  output logic [CODE_W-1:0] ctl_word,
  output logic              ctl_le
);
  seq_state_e       state, state_nx;
  logic [CNT_W-1:0] win, win_nx;
  logic [CODE_W-1:0] word_q;
  logic             le_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_nx = state;
    win_nx   = win;
    case (state)
      ST_IDLE: if (req_valid) begin
        state_nx = ST_SETUP;
        win_nx   = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (win == '0) begin
        state_nx = ST_PULSE;
        win_nx   = CNT_W'(PULSE_CYC - 1);
      end else win_nx = win - 1'b1;
      ST_PULSE: if (win == '0) begin
        state_nx = ST_HOLD;
        win_nx   = CNT_W'(HOLD_CYC - 1);
      end else win_nx = win - 1'b1;
      ST_HOLD: if (win == '0) state_nx = ST_GAP;
               else win_nx = win - 1'b1;
      ST_GAP:  if (space_done) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      win    <= '0;
      word_q <= '0;
      le_q   <= 1'b0;
    end else begin
      state <= state_nx;
      win   <= win_nx;
      le_q  <= (state_nx == ST_PULSE);
      if (accept) word_q <= code_in;
    end
  end

  assign ctl_word = word_q;
  assign ctl_le   = le_q;

  // Assertion support counters: strobe high run, word-stable run, cycles since strobe fell.
  logic [CNT_W-1:0]  hi_run, stab_run, low_run;
  logic [CODE_W-1:0] word_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= '0;
      stab_run  <= '0;
      low_run   <= CNT_W'(HOLD_CYC);
      word_prev <= '0;
    end else begin
      word_prev <= ctl_word;
      hi_run    <= ctl_le ? hi_run + 1'b1 : '0;
      if (ctl_word != word_prev)                  stab_run <= CNT_W'(1);
      else if (stab_run < CNT_W'(SETUP_CYC))      stab_run <= stab_run + 1'b1;
      if (ctl_le)                                 low_run <= '0;
      else if (low_run < CNT_W'(HOLD_CYC))        low_run <= low_run + 1'b1;
    end
  end

  AST_WORD_MOVES_LE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_word) |-> (!ctl_le && !$past(ctl_le))); // R7
  AST_READY_NOT_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ctl_le); // R9
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_le) |-> hi_run == CNT_W'(PULSE_CYC)); // R5
  AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_le) |-> stab_run >= CNT_W'(SETUP_CYC)); // R4
  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_word) |-> low_run >= CNT_W'(HOLD_CYC)); // R6
endmodule

// File: rtl/atten_latch_seq.sv
module atten_latch_seq
  import atten_seq_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int SETUP_NS  = 10,
  parameter int PULSE_NS  = 10,
  parameter int HOLD_NS   = 10,
  parameter int PERIOD_NS = 1000,
  parameter int REQ_W     = 8,
  parameter int CODE_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REQ_W-1:0]  req_steps,
  output logic [CODE_W-1:0] ctl_word,
  output logic              ctl_le,
  output logic              clip_seen
);
  localparam int SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_MHZ);
  localparam int PULSE_CYC = ns_to_cyc(PULSE_NS, CLK_MHZ);
  localparam int HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_MHZ);
  localparam int SPACE_CYC = max2(ns_to_cyc(PERIOD_NS, CLK_MHZ),
                                  SETUP_CYC + PULSE_CYC + HOLD_CYC + 1);
  localparam int CNT_W     = $clog2(SPACE_CYC + 1);

  logic [CODE_W-1:0] sat_code;
  logic              sat_clip;
  logic              accept;
  logic              space_done;
  logic              clip_q;

  atten_code_sat #(.IN_W(REQ_W), .CODE_W(CODE_W)) u_sat (
    .steps_in (req_steps),
    .code_out (sat_code),
    .clipped  (sat_clip)
  );

  atten_space_timer #(.SPACE_CYC(SPACE_CYC), .CNT_W(CNT_W)) u_space (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .done  (space_done)
  );

  atten_seq_fsm #(
    .CODE_W(CODE_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .code_in    (sat_code),
    .space_done (space_done),
    .req_ready  (req_ready),
    .accept     (accept),
    .ctl_word   (ctl_word),
    .ctl_le     (ctl_le)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    clip_q <= 1'b0;
    else if (accept && sat_clip)   clip_q <= 1'b1;
  end
  assign clip_seen = clip_q;

  AST_CLIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clip_seen) |-> clip_seen); // R3
  AST_CLIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clip_seen) |-> $past(req_valid && req_ready && (req_steps > REQ_W'((1 << CODE_W) - 1)))); // R3
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_steps > REQ_W'((1 << CODE_W) - 1))) |=> (ctl_word == {CODE_W{1'b1}})); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_steps <= REQ_W'((1 << CODE_W) - 1))) |=> (ctl_word == $past(req_steps[CODE_W-1:0]))); // R1
endmodule

// File: tb/atten_latch_seq_tb.sv
module atten_latch_seq_tb;
  // 25/15/35 ns at 100 MHz round up to 3/2/4 cycles; 1000 ns gives 100 cycles.
  localparam int EXP_SETUP = 3;
  localparam int EXP_PULSE = 2;
  localparam int EXP_HOLD  = 4;
  localparam int EXP_SPACE = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_steps = '0;
  logic       req_ready;
  logic [5:0] ctl_word;
  logic       ctl_le;
  logic       clip_seen;

  int n_chk = 0, n_bad = 0, n_sent = 0, n_acc = 0, n_pulse = 0;
  int exp_q[$];
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  atten_latch_seq #(
    .CLK_MHZ(100), .SETUP_NS(25), .PULSE_NS(15), .HOLD_NS(35),
    .PERIOD_NS(1000), .REQ_W(8), .CODE_W(6)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_steps(req_steps), .ctl_word(ctl_word), .ctl_le(ctl_le), .clip_seen(clip_seen)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int s);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_steps = s[7:0];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(s);
    n_sent++;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
  endtask

  // Monitor / scoreboard
  int cyc = 0, last_acc = -100000;
  int stab_run = 0, hi_run = 0, since_fall = 1000000;
  logic [5:0] prev_word = '0;
  logic       prev_le = 1'b0;

  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (ctl_le && !prev_le) chk(stab_run == EXP_SETUP, "R4 setup cycles", stab_run, EXP_SETUP);
      if (!ctl_le && prev_le) begin
        int raw, expw;
        n_pulse++;
        chk(hi_run == EXP_PULSE, "R5 pulse cycles", hi_run, EXP_PULSE);
        if (exp_q.size() == 0) chk(1'b0, "R9 strobe without request", n_pulse, n_sent);
        else begin
          raw  = exp_q.pop_front();
          expw = (raw > 63) ? 63 : raw;
          chk(int'(ctl_word) == expw, (raw > 63) ? "R2 clipped word" : "R1 word", int'(ctl_word), expw);
        end
      end
      if (ctl_word != prev_word) begin
        chk(since_fall >= EXP_HOLD, "R6 hold cycles", since_fall, EXP_HOLD);
        chk(!ctl_le && !prev_le, "R7 word change with strobe low", int'(ctl_le), 0);
      end
      if (req_ready && ctl_le) chk(1'b0, "R9 ready during strobe", 1, 0);
      if (req_valid && req_ready) begin
        chk(cyc - last_acc >= EXP_SPACE, "R8 spacing", cyc - last_acc, EXP_SPACE);
        last_acc = cyc;
        n_acc++;
      end
      stab_run   = (ctl_word != prev_word) ? 1 : stab_run + 1;
      hi_run     = ctl_le ? (prev_le ? hi_run + 1 : 1) : 0;
      since_fall = ctl_le ? 0 : ((!ctl_le && prev_le) ? 1 : since_fall + 1);
      prev_word  = ctl_word;
      prev_le    = ctl_le;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ctl_le == 1'b0, "R10 reset le", int'(ctl_le), 0);
    chk(ctl_word == 6'd0, "R10 reset word", int'(ctl_word), 0);
    chk(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
    chk(clip_seen == 1'b0, "R10 reset clip", int'(clip_seen), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    mon_en = 1'b1;

    send(5);  wait_idle();
    send(42); wait_idle();
    send(0);  wait_idle();
    send(63); wait_idle();
    chk(clip_seen == 1'b0, "R3 no clip at 63", int'(clip_seen), 0);
    send(37); send(21); wait_idle();   // back-to-back: held valid, spacing
    send(64); wait_idle();
    chk(clip_seen == 1'b1, "R3 clip at 64", int'(clip_seen), 1);
    send(17); wait_idle();
    chk(clip_seen == 1'b1, "R3 clip sticky", int'(clip_seen), 1);
    send(255); send(1); send(32); wait_idle();
    repeat (10) @(negedge clk);
    chk(n_acc == n_sent, "R9 one transfer per request", n_acc, n_sent);
    chk(n_pulse == n_sent, "R9 one strobe per request", n_pulse, n_sent);
    chk(ctl_word == 6'd32, "R1 final word held", int'(ctl_word), 32);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule